// File: doc/BRIEF.md
# Programmable Clock Divider Bank

This block takes one fast clock and derives from it three banks of divided clocks (A, B and C), a feedback clock, a fourth bank D and a coincidence flag named SYNC. A 4-bit bank code picks the A/B/C divide ratios from a fixed table of sixteen even ratios. A 3-bit feedback code picks the ratio of the feedback clock. An optional prescaler halves the input before any divider sees it. Bank D shows either the SYNC flag or a copy of bank C.

The whole block runs on the input clock and uses a clock-enable "tick" from the prescaler, so it holds no derived clock domains. A synchronous active-low master reset clears every output, captures the selects and rearms every divider. Because of this, the first rising edges of all outputs after reset fall on the same tick. The selects are captured only while reset is held, so a new configuration takes effect only through a fresh reset. SYNC marks the ticks where banks A and C rise together. This is useful when the two ratios are not multiples of each other, such as 6:4 or 8:6.

Top module: `clkdiv_bank`

## Requirements
- R1: While `rst_n` is sampled low, `qa`, `qb`, `qc`, `qfb` and `sync_o` are low at the next edge, and `qd` is low as well.
- R2: `bank_sel` picks the ratios A/B/C as follows. 0:2/2/2, 1:2/2/4, 2:2/4/4, 3:2/2/6, 4:2/6/6, 5:2/4/6, 6:2/4/8, 7:2/6/8, 8:2/2/8, 9:2/8/8, 10:4/4/6, 11:4/6/6, 12:4/6/8, 13:6/6/8, 14:6/8/8, 15:8/8/8. The rising edges of each bank are N ticks apart.
- R3: Every output has a 50% duty cycle: it stays high for N/2 ticks and then low for N/2 ticks.
- R4: `fb_sel` picks the feedback ratio. With bit 2 clear, the ratio is 2·(k+1), where k is `fb_sel[1:0]`. With bit 2 set, the ratio is 8·(k+1).
- R5: With `prescale` high, a tick occurs on every second input clock edge. With `prescale` low, every input edge is a tick.
- R6: After reset release, all divided outputs rise together on the first tick. Without prescale, that tick is the first edge with `rst_n` high. With prescale, it is the second such edge.
- R7: `sync_o` goes high on each tick where A and C rise together. It goes low on the next tick where only the faster of the two rises. So it stays high for one period of the faster bank after each coincidence, and it stays high all the time when the two ratios are equal.
- R8: `qd` follows `sync_o` when `d_sel` is 0 and follows `qc` when `d_sel` is 1. `d_sel` acts at all times.
- R9: Changes to `bank_sel`, `fb_sel` and `prescale` while `rst_n` is high have no effect on any output until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| prescale | input | 1 | 1 = halve the input clock before the dividers |
| bank_sel | input | 4 | Bank A/B/C ratio code |
| fb_sel | input | 3 | Feedback ratio code |
| d_sel | input | 1 | 0 = bank D shows SYNC, 1 = bank D copies bank C |
| qa | output | 1 | Bank A clock |
| qb | output | 1 | Bank B clock |
| qc | output | 1 | Bank C clock |
| qd | output | 1 | Bank D output |
| qfb | output | 1 | Feedback clock |
| sync_o | output | 1 | A/C rising-edge coincidence flag |

## Verification
The assertions check the following on every cycle:
- the reset state of all outputs;
- that SYNC rises only together with both A and C;
- that a joint rise of A and C always raises SYNC;
- that with prescale, no output changes on two clock edges in a row.

Only the bench's scenarios can show the exact ratios for each of the sixteen bank codes and eight feedback codes, the edge of the first rise after release, the duty cycle and the full SYNC waveform. The same holds for the claim that select changes after release are ignored, since that needs the expected waveform of the configuration that was captured.

// File: rtl/clkdiv_pkg.sv
// Package: shared ratio types and the select decoders for the divider bank.
// Assumes: all ratios are even and no larger than 32.
package clkdiv_pkg;

    typedef struct packed {
        logic [3:0] a;
        logic [3:0] b;
        logic [3:0] c;
    } bank_ratio_t;

    // Decode the 4-bit bank code into the A/B/C divide ratios.
    function automatic bank_ratio_t decode_bank(input logic [3:0] code);
        bank_ratio_t r;
        case (code)
            4'd0:    r = '{a: 4'd2, b: 4'd2, c: 4'd2};
            4'd1:    r = '{a: 4'd2, b: 4'd2, c: 4'd4};
            4'd2:    r = '{a: 4'd2, b: 4'd4, c: 4'd4};
            4'd3:    r = '{a: 4'd2, b: 4'd2, c: 4'd6};
            4'd4:    r = '{a: 4'd2, b: 4'd6, c: 4'd6};
            4'd5:    r = '{a: 4'd2, b: 4'd4, c: 4'd6};
            4'd6:    r = '{a: 4'd2, b: 4'd4, c: 4'd8};
            4'd7:    r = '{a: 4'd2, b: 4'd6, c: 4'd8};
            4'd8:    r = '{a: 4'd2, b: 4'd2, c: 4'd8};
            4'd9:    r = '{a: 4'd2, b: 4'd8, c: 4'd8};
            4'd10:   r = '{a: 4'd4, b: 4'd4, c: 4'd6};
            4'd11:   r = '{a: 4'd4, b: 4'd6, c: 4'd6};
            4'd12:   r = '{a: 4'd4, b: 4'd6, c: 4'd8};
            4'd13:   r = '{a: 4'd6, b: 4'd6, c: 4'd8};
            4'd14:   r = '{a: 4'd6, b: 4'd8, c: 4'd8};
            default: r = '{a: 4'd8, b: 4'd8, c: 4'd8};
        endcase
        return r;
    endfunction

    // Decode the 3-bit feedback code: a small step of 2 or a large step of 8.
    function automatic logic [5:0] decode_fb(input logic [2:0] code);
        logic [5:0] step;
        step = code[2] ? 6'd8 : 6'd2;
        return step * ({4'd0, code[1:0]} + 6'd1);
    endfunction

endpackage

// File: rtl/clkdiv_prescale.sv
// Module: clkdiv_prescale
// Produces the divider clock-enable. With halving on, the tick is high on
// every second edge, starting with the second edge after reset release.
// Assumes: synchronous active-low reset; halve is steady outside reset.
module clkdiv_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic halve,
    output logic tick
);
    logic phase;

    // Alternate the phase flop on every edge; hold it clear in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    assign tick = rst_n && (!halve || phase);
endmodule

// File: rtl/clkdiv_counter.sv
// Module: clkdiv_counter
// Even-ratio divider running on a clock-enable. A down-counter reloads with
// ratio-1 on every rising edge. The output stays high while the counter is in
// the upper half, which gives a 50% duty cycle. In reset the counter sits at
// zero, so the first tick after release makes a rising edge.
// Assumes: ratio is even, at least 2, and steady outside reset.
module clkdiv_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         rise,
    output logic         q
);
    logic [W-1:0] cnt;
    logic [W-1:0] cnt_next;
    logic [W-1:0] half;

    assign half = ratio >> 1;
    assign rise = tick && (cnt == '0);

    // Next count: reload at zero, otherwise step down.
    always_comb begin
        if (cnt == '0) cnt_next = ratio - W'(1);
        else           cnt_next = cnt - W'(1);
    end

    // Advance the counter and the output level on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            q   <= 1'b0;
        end else if (tick) begin
            cnt <= cnt_next;
            q   <= (cnt_next >= half);
        end
    end
endmodule

// File: rtl/clkdiv_sync.sv
// Module: clkdiv_sync
// Coincidence flag. It goes high on a tick where banks A and C rise together.
// It goes low on a later tick where only the faster of the two rises.
// Assumes: ratios are steady outside reset; rise strobes are tick-qualified.
module clkdiv_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_a,
    input  logic         rise_c,
    input  logic [W-1:0] ratio_a,
    input  logic [W-1:0] ratio_c,
    output logic         flag
);
    logic fast_rise;

    assign fast_rise = (ratio_a <= ratio_c) ? rise_a : rise_c;

    // Set on a joint rise, clear on a lone rise of the faster bank.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag <= 1'b0;
        else if (rise_a && rise_c) flag <= 1'b1;
        else if (fast_rise)        flag <= 1'b0;
    end
endmodule

// File: rtl/clkdiv_bank.sv
// Module: clkdiv_bank (top)
// Clock divider bank with banks A/B/C, a feedback output, bank D and a SYNC
// flag. The selects are captured while rst_n is low, and every divider
// restarts together on release.
// Assumes: synchronous active-low reset held for at least one edge after any
// select change; all logic runs on clk gated by a prescaler tick.
module clkdiv_bank #(
    parameter int DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prescale,
    input  logic [3:0] bank_sel,
    input  logic [2:0] fb_sel,
    input  logic       d_sel,
    output logic       qa,
    output logic       qb,
    output logic       qc,
    output logic       qd,
    output logic       qfb,
    output logic       sync_o
);
    import clkdiv_pkg::*;

    localparam int NCH = 4;          // A, B, C, feedback
    localparam int CH_A = 0;
    localparam int CH_C = 2;

    logic        pre_q;
    logic [3:0]  bank_q;
    logic [2:0]  fb_q;
    logic        tick;
    bank_ratio_t br;
    logic [DIV_W-1:0] ratio [NCH];
    logic [NCH-1:0]   rise;
    logic [NCH-1:0]   qv;
    logic             sync_q;

    // Capture the configuration only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= prescale;
            bank_q <= bank_sel;
            fb_q   <= fb_sel;
        end
    end

    // Decode the captured codes into per-channel ratios.
    always_comb begin
        br = decode_bank(bank_q);
        ratio[0] = DIV_W'(br.a);
        ratio[1] = DIV_W'(br.b);
        ratio[2] = DIV_W'(br.c);
        ratio[3] = DIV_W'(decode_fb(fb_q));
    end

    clkdiv_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .halve (pre_q),
        .tick  (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        clkdiv_counter #(.W(DIV_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .ratio (ratio[i]),
            .rise  (rise[i]),
            .q     (qv[i])
        );
    end

    clkdiv_sync #(.W(DIV_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_a  (rise[CH_A]),
        .rise_c  (rise[CH_C]),
        .ratio_a (ratio[CH_A]),
        .ratio_c (ratio[CH_C]),
        .flag    (sync_q)
    );

    assign qa     = qv[0];
    assign qb     = qv[1];
    assign qc     = qv[2];
    assign qfb    = qv[3];
    assign sync_o = sync_q;
    assign qd     = d_sel ? qv[2] : sync_q;
endmodule

// File: rtl/clkdiv_bank_chk.sv
// Module: clkdiv_bank_chk
// Property checker bound to clkdiv_bank; it observes outputs and the
// captured prescale setting.
module clkdiv_bank_chk (
    input logic clk,
    input logic rst_n,
    input logic pre_q,
    input logic qa,
    input logic qb,
    input logic qc,
    input logic qd,
    input logic qfb,
    input logic sync_o
);
    // R1: a reset edge leaves every output low.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!qa && !qb && !qc && !qd && !qfb && !sync_o));

    // R7: SYNC rises only together with both A and C.
    a_r7_sync_with_edges: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> (qa && qc && $rose(qa) && $rose(qc)));

    // R7: a joint rise of A and C always leaves SYNC high.
    a_r7_joint_sets_sync: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(qa) && $rose(qc)) |-> sync_o);

    // R5: with the prescaler on, no output changes on consecutive edges.
    a_r5_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q && ($changed(qa) || $changed(qfb))) |=> ($stable(qa) && $stable(qfb)));
endmodule

bind clkdiv_bank clkdiv_bank_chk chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pre_q  (pre_q),
    .qa     (qa),
    .qb     (qb),
    .qc     (qc),
    .qd     (qd),
    .qfb    (qfb),
    .sync_o (sync_o)
);

// File: tb/clkdiv_bank_test.sv
module clkdiv_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prescale = 1'b0;
    logic [3:0] bank_sel = 4'd0;
    logic [2:0] fb_sel = 3'd0;
    logic       d_sel = 1'b0;
    logic qa, qb, qc, qd, qfb, sync_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    clkdiv_bank uut (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .bank_sel(bank_sel),
        .fb_sel(fb_sel), .d_sel(d_sel), .qa(qa), .qb(qb), .qc(qc), .qd(qd),
        .qfb(qfb), .sync_o(sync_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_ratio(input int code, input int ch);
        int t [16][3] = '{'{2,2,2},'{2,2,4},'{2,4,4},'{2,2,6},'{2,6,6},'{2,4,6},
                          '{2,4,8},'{2,6,8},'{2,2,8},'{2,8,8},'{4,4,6},'{4,6,6},
                          '{4,6,8},'{6,6,8},'{6,8,8},'{8,8,8}};
        return t[code][ch];
    endfunction

    function automatic int ref_fb(input int code);
        return ((code >= 4) ? 8 : 2) * ((code % 4) + 1);
    endfunction

    function automatic int gcd(input int a, input int b);
        int x = a; int y = b;
        while (y != 0) begin int t = x % y; x = y; y = t; end
        return x;
    endfunction

    // One configuration: reset with the selects, release, and measure the edges.
    // If scramble is set, the selects are changed after release (R9).
    task automatic run_cfg(input int bs, input int fs, input bit pre, input bit ds,
                           input bit scramble);
        int nr [4];
        int r1 [4]; int r2 [4]; int f1 [4];
        int prev [4];
        int cur [4];
        int p, t1, na, nc, l, nmin, sync_err, qd_err;
        string tag;
        @(negedge clk);
        rst_n = 1'b0; bank_sel = 4'(bs); fb_sel = 3'(fs); prescale = pre; d_sel = ds;
        repeat (3) @(negedge clk);
        check("R1", "reset outputs", int'({qa, qb, qc, qd, qfb, sync_o}), 0);
        for (int i = 0; i < 3; i++) nr[i] = ref_ratio(bs, i);
        nr[3] = ref_fb(fs);
        p  = pre ? 2 : 1;
        t1 = pre ? 2 : 1;
        na = nr[0]; nc = nr[2];
        l  = na * nc / gcd(na, nc);
        nmin = (na < nc) ? na : nc;
        for (int i = 0; i < 4; i++) begin r1[i] = -1; r2[i] = -1; f1[i] = -1; prev[i] = 0; end
        sync_err = 0; qd_err = 0;
        rst_n = 1'b1;
        for (int s = 1; s <= 160; s++) begin
            @(negedge clk);
            if (scramble && s == 3) begin
                bank_sel = ~bank_sel; fb_sel = ~fb_sel; prescale = ~prescale;
            end
            cur[0] = qa; cur[1] = qb; cur[2] = qc; cur[3] = qfb;
            for (int i = 0; i < 4; i++) begin
                if (cur[i] == 1 && prev[i] == 0) begin
                    if (r1[i] < 0) r1[i] = s; else if (r2[i] < 0) r2[i] = s;
                end
                if (cur[i] == 0 && prev[i] == 1 && f1[i] < 0) f1[i] = s;
                prev[i] = cur[i];
            end
            begin
                int exp_sync = 0;
                if (s >= t1) begin
                    int j = (s - t1) / p;
                    exp_sync = ((j % l) < nmin) ? 1 : 0;
                end
                if (int'(sync_o) != exp_sync) sync_err++;
                if (int'(qd) != (ds ? int'(qc) : int'(sync_o))) qd_err++;
            end
        end
        tag = scramble ? "R9" : (pre ? "R5" : "R2");
        for (int i = 0; i < 4; i++) begin
            check("R6", $sformatf("first rise ch%0d bs%0d", i, bs), r1[i], t1);
            check(i == 3 ? "R4" : tag, $sformatf("period ch%0d bs%0d fs%0d", i, bs, fs),
                  r2[i] - r1[i], nr[i] * p);
            check("R3", $sformatf("high time ch%0d bs%0d", i, bs), f1[i] - r1[i], nr[i] / 2 * p);
        end
        check("R7", $sformatf("sync mismatches bs%0d", bs), sync_err, 0);
        check("R8", $sformatf("qd mismatches ds%0d", ds), qd_err, 0);
    endtask

    task automatic test_all_codes();
        for (int c = 0; c < 16; c++) run_cfg(c, c % 8, 1'b0, c[0], 1'b0);
    endtask

    task automatic test_prescale();
        run_cfg(12, 7, 1'b1, 1'b0, 1'b0);
        run_cfg(13, 4, 1'b1, 1'b1, 1'b0);
        run_cfg(10, 3, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_ignore_changes();
        run_cfg(11, 5, 1'b0, 1'b0, 1'b1);
        run_cfg(14, 2, 1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        fork
            begin
                test_all_codes();
                test_prescale();
                test_ignore_changes();
                finished = 1;
            end
            begin
                repeat (150000) @(posedge clk);
            end
        join_any
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule